// File: doc/BRIEF.md
# Edge Trigger Priority Vector Controller

This block watches eight active-low trigger pins, a power-on/reset event and a jump request from an instruction sequencer, and turns them into a stream of interrupt vector numbers. Each pin has pull-up semantics, so it idles high. The pin passes through a two-flop synchroniser and then a debounce filter, whose window is counted in ticks of an internal prescaler. Edges are then detected on the debounced level. A falling edge and a rising edge on the same pin are enabled separately, and each maps to its own vector.

An enabled edge is latched as a pending event. On every cycle the controller grants the pending event with the highest priority. It reports that event's vector with a one-cycle strobe and clears only that event's pending bit. When several events coincide, they are reported on consecutive cycles in priority order. Power-on/reset always comes first and the jump request always comes last.

A small write port loads two enable registers and the debounce-length select.

Top module: `trig_vector_arb`

## Requirements
- R1: While reset is asserted `out_valid` is 0. Reset leaves both enable registers at 0xFF and the long debounce window selected. The power-on event is pending after reset, so the first strobe after reset reports vector 32.
- R2: A debounced pin level changes only after the synchronised input has held the new level for the whole debounce window. A pulse shorter than the window produces no vector.
- R3: Writing `wr_sel`=2 sets the window from `wr_data[0]`. A value of 1 selects LONG_TICKS prescaler ticks and 0 selects SHORT_TICKS. A pulse longer than the short window but shorter than the long window is reported only while the short window is selected.
- R4: For pin index k (0..7, pin k is `trig_n[k]`), a falling edge reports vector (k/4)*8 + k%4 and a rising edge reports that value plus 4. This gives vectors 0..3 and 8..11 for falling edges and 4..7 and 12..15 for rising edges.
- R5: Enable register 0 (`wr_sel`=0) holds pins 0..3 and enable register 1 (`wr_sel`=1) holds pins 4..7. In each register, bit (k%4) enables the falling edge of pin k and bit 4+(k%4) enables its rising edge. An edge whose enable bit is 0 produces no vector.
- R6: Coincident events are reported one per cycle in this order: power-on, then pin 0 falling, pin 0 rising, pin 1 falling, pin 1 rising, and so on through pin 7 rising, then the jump request.
- R7: A `por_evt` pulse reports vector 32 ahead of any trigger or jump request that is pending at the same time.
- R8: A `jp_req` pulse is latched together with `jp_vec`. It reports that vector after every other pending event.
- R9: A write to an enable register does not remove edges that are already pending. Those edges are still reported.
- R10: Every latched event produces exactly one strobe. No strobe occurs while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also raises the power-on event |
| por_evt | input | 1 | Power-on/reset event pulse |
| trig_n | input | 8 | Active-low trigger pins, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0: enable reg 0, 1: enable reg 1, 2: debounce select |
| wr_data | input | 8 | Write data |
| jp_req | input | 1 | Jump request pulse from the sequencer |
| jp_vec | input | VEC_W | Target vector of the jump request |
| out_valid | output | 1 | One-cycle strobe for a granted event |
| out_vec | output | VEC_W | Vector number of the granted event |

## Verification
Three properties are checked on every cycle. A pending power-on event must yield vector 32 on the next cycle. A strobe must follow exactly when something is pending. A debounced level may move only toward the previous synchronised value. The bench scenarios are needed to show the rest: the vector map of all sixteen edges, the masking effect of each enable bit, and the difference between the short and long windows for a pulse of intermediate length. They also show the full ordering of coincident edges and jump requests, and that pending edges survive an enable write.

// File: rtl/trig_vector_arb.sv
module trig_vector_arb #(
  parameter int TICK_DIV    = 150,
  parameter int SHORT_TICKS = 8,
  parameter int LONG_TICKS  = 1000,
  parameter int VEC_W       = 11,
  parameter int POI_VEC     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_evt,
  input  logic [7:0]       trig_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             jp_req,
  input  logic [VEC_W-1:0] jp_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec
);
  localparam int NT = 8;
  localparam int NE = 2 * NT + 2;
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [DW-1:0]    div;
  logic             tick;
  logic [NT-1:0]    s1, s2, deb, deb_d;
  logic [CW-1:0]    cnt [NT];
  logic [CW-1:0]    win;
  logic [15:0]      en;
  logic             long_sel;
  logic [2*NT-1:0]  ev;
  logic [NE-1:0]    pend, clr;
  logic [VEC_W-1:0] jp_hold, gvec;

  assign tick = (div == DW'(TICK_DIV - 1));
  assign win  = long_sel ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= tick ? '0 : div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; deb <= '1; deb_d <= '1;
      for (int k = 0; k < NT; k++) cnt[k] <= '0;
    end else begin
      s1    <= trig_n;
      s2    <= s1;
      deb_d <= deb;
      for (int k = 0; k < NT; k++)
        if (s2[k] == deb[k]) cnt[k] <= '0;
        else if (tick) begin
          if (cnt[k] + 1'b1 >= win) begin
            deb[k] <= s2[k];
            cnt[k] <= '0;
          end else cnt[k] <= cnt[k] + 1'b1;
        end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 16'hFFFF; long_sel <= 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: en[7:0]  <= wr_data;
        2'd1: en[15:8] <= wr_data;
        2'd2: long_sel <= wr_data[0];
        default: ;
      endcase
    end

  for (genvar k = 0; k < NT; k++) begin : g_edge
    localparam int FB = (k / 4) * 8 + k % 4;
    assign ev[2*k]   =  deb_d[k] & ~deb[k] & en[FB];
    assign ev[2*k+1] = ~deb_d[k] &  deb[k] & en[FB+4];
  end

  function automatic logic [VEC_W-1:0] vec_of(input int i);
    int k;
    k = (i - 1) / 2;
    return VEC_W'((k / 4) * 8 + k % 4 + 4 * ((i - 1) % 2));
  endfunction

  always_comb begin
    clr  = '0;
    gvec = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (pend[i]) begin
        clr     = '0;
        clr[i]  = 1'b1;
        gvec    = (i == 0) ? VEC_W'(POI_VEC) : (i == NE - 1) ? jp_hold : vec_of(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend      <= NE'(1);
      jp_hold   <= '0;
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      pend      <= (pend & ~clr) | {jp_req, ev, por_evt};
      if (jp_req) jp_hold <= jp_vec;
      out_valid <= |pend;
      out_vec   <= gvec;
    end

  a_r7_poi_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |=> (out_valid && out_vec == VEC_W'(POI_VEC)));

  a_r6_busy_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> out_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !out_valid);

  a_r2_deb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((deb ^ $past(deb)) & (deb ^ $past(s2))) == '0);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[2*NT:1] == '0 && ev == '0) |=> pend[2*NT:1] == '0);
endmodule

// File: tb/trig_vector_arb_tb.sv
module trig_vector_arb_tb;
  localparam int VW = 11;
  logic clk = 1'b0, rst_n = 1'b0, por_evt = 1'b0, wr_en = 1'b0, jp_req = 1'b0;
  logic [7:0]    trig_n = 8'hFF, wr_data = 8'h00;
  logic [1:0]    wr_sel = 2'd0;
  logic [VW-1:0] jp_vec = '0;
  logic          out_valid;
  logic [VW-1:0] out_vec;
  int errors = 0, checks = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_vector_arb #(.TICK_DIV(4), .SHORT_TICKS(3), .LONG_TICKS(12), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .trig_n(trig_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .jp_req(jp_req), .jp_vec(jp_vec),
    .out_valid(out_valid), .out_vec(out_vec));

  task automatic expect_vec(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) if (rst_n && out_valid) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected strobe: actual vec=%0d expected none", out_vec);
    end else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (out_vec !== VW'(e)) begin
        errors++;
        $display("FAIL %s: actual vec=%0d expected %0d", t, out_vec, e);
      end
    end
  end

  task automatic settle(input string tag);
    repeat (90) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d vectors missing, expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] mask, input int len);
    @(negedge clk);
    trig_n = trig_n & ~mask;
    repeat (len) @(negedge clk);
    trig_n = trig_n | mask;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual out_valid=%b expected 0", out_valid);
    end
    expect_vec(32, "R1 power-on vector");
    rst_n = 1'b1;
    settle("R1");

    // R2/R4: long-held press under default long window
    expect_vec(0, "R4 pin0 fall"); expect_vec(4, "R4 pin0 rise");
    pulse(8'h01, 120);
    settle("R4");

    write_reg(2'd2, 8'h00);
    // R2: glitch shorter than the short window is ignored
    pulse(8'h01, 4);
    settle("R2 glitch");

    // R3: medium pulse accepted with short window, dropped with long window
    expect_vec(10, "R3 short fall"); expect_vec(14, "R3 short rise");
    pulse(8'h40, 30);
    settle("R3 short");
    write_reg(2'd2, 8'h01);
    pulse(8'h40, 30);
    settle("R3 long ignores");
    expect_vec(11, "R3 long fall"); expect_vec(15, "R3 long rise");
    pulse(8'h80, 120);
    settle("R3 long");
    write_reg(2'd2, 8'h00);

    // R4: full map
    for (int k = 0; k < 8; k++) begin
      expect_vec((k / 4) * 8 + k % 4, "R4 map fall");
      expect_vec((k / 4) * 8 + k % 4 + 4, "R4 map rise");
      pulse(8'(1 << k), 40);
      settle("R4 map");
    end

    // R6: coincident edges
    expect_vec(0, "R6 order"); expect_vec(3, "R6 order"); expect_vec(9, "R6 order");
    expect_vec(4, "R6 order"); expect_vec(7, "R6 order"); expect_vec(13, "R6 order");
    pulse(8'h29, 40);
    settle("R6");
    expect_vec(0, "R6 pin0 fall");
    pulse(8'h01, 0);
    @(negedge clk); trig_n = 8'hFE;
    settle("R6 prep");
    expect_vec(4, "R6 rise before next fall"); expect_vec(1, "R6 rise before next fall");
    @(negedge clk); trig_n = 8'hFD;
    repeat (40) @(negedge clk);
    expect_vec(5, "R6 pin1 rise");
    trig_n = 8'hFF;
    settle("R6 mixed");

    // R5: enable masks
    write_reg(2'd0, 8'h0F);
    expect_vec(1, "R5 falling only");
    pulse(8'h02, 40);
    settle("R5 en0");
    write_reg(2'd1, 8'h10);
    expect_vec(12, "R5 pin4 rise only");
    pulse(8'h10, 40);
    settle("R5 en1");
    write_reg(2'd0, 8'hFF);
    write_reg(2'd1, 8'hFF);

    // R7/R8: power-on beats a coincident jump request
    expect_vec(32, "R7 power-on first"); expect_vec(12'h2A5 & 11'h7FF, "R8 jump last");
    @(negedge clk); por_evt = 1'b1; jp_req = 1'b1; jp_vec = 11'h2A5;
    @(negedge clk); por_evt = 1'b0; jp_req = 1'b0;
    settle("R7");
    expect_vec(11'h7FF, "R8 jump alone");
    @(negedge clk); jp_req = 1'b1; jp_vec = 11'h7FF;
    @(negedge clk); jp_req = 1'b0;
    settle("R8");

    // R9: disabling while edges are pending keeps them
    expect_vec(0, "R9 pending kept"); expect_vec(1, "R9 pending kept");
    expect_vec(2, "R9 pending kept");
    @(negedge clk); trig_n = 8'hF8;
    while (!out_valid) @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    repeat (40) @(negedge clk);
    trig_n = 8'hFF;
    settle("R9");
    write_reg(2'd0, 8'hFF);
    settle("R10 end");
    finish_run();
  end
endmodule